// File: doc/BRIEF.md
# Scoreboard Dynamic Scheduling Controller

This block is the central scheduler of a floating-point back end that issues in program order and lets execution and completion run out of order. Decoded instructions arrive one at a time on a valid/ready interface, each carrying an operation class, one destination register and two source registers. The block owns five non-pipelined functional units: one integer/memory unit, two multipliers, one adder and one divider. For each instruction it decides when the instruction may issue to a unit, when that unit may read its operands, and when the unit may write its result back. It signals each decision as a one-cycle grant event. Operand values, the register file itself and memory addressing belong to the surrounding datapath.

Each unit runs a four-state machine. `FU_IDLE` moves to `FU_WAIT_OPS` on issue. `FU_WAIT_OPS` moves to `FU_EXEC` once both source-ready flags are set; that is the operand-read grant. `FU_EXEC` counts the unit's latency down and then moves to `FU_WAIT_WB`. `FU_WAIT_WB` returns to `FU_IDLE` when the write-back grant is given.

The three kinds of hazard are handled at different points, and every decision is made from the per-unit records and a per-register table of pending writers:
- A destination clash (WAW) stops issue.
- A source produced by an unfinished instruction (RAW) stops operand read.
- A unit whose destination is still needed as an old value by a waiting reader (WAR) is held at write-back.

Top module: `sb_sched_ctrl`

## Requirements
- R1: After reset every unit is free, no grant is asserted, and `in_ready` is high for any class and any destination.
- R2: Class codes and units are fixed. Code 0 is integer/memory: unit 0, 1 execute cycle. Code 1 is multiply: units 1 and 2, 10 cycles. Code 2 is add: unit 3, 2 cycles. Code 3 is divide: unit 4, 40 cycles. Issue picks the lowest-index free unit of the class. When the sources are ready, `rd_grant` rises in the cycle after the issue edge, and `wb_grant` rises LAT+1 cycles after `rd_grant`, where LAT is the unit's execute latency.
- R3: Issue stalls (`in_ready` low) while no unit of the requested class is in `FU_IDLE`.
- R4: Issue stalls while any active instruction already has the requested destination register. It resumes in the cycle after that instruction's write-back grant.
- R5: Issue is in program order. `iss_grant` is one-hot with the chosen unit on the cycle of a handshake, and it is zero whenever `in_ready` is low.
- R6: A source written by an earlier active instruction is not ready. The consumer's `rd_grant` comes in the cycle after the producer's `wb_grant`.
- R7: `rd_grant` for a unit is a single-cycle pulse per instruction. After the read, both ready flags are cleared.
- R8: A finished unit is held at write-back while another unit in `FU_WAIT_OPS` still has an unread source, with its ready flag set, that equals the finished unit's destination. The write-back goes ahead in the cycle after that reader's `rd_grant`.
- R9: At most one `wb_grant` per cycle. When several units are eligible, the lowest index wins. `wb_reg` shows the destination register of the granted unit.
- R10: Issue does not see the effects of a write-back in the same cycle. A unit freed by a write-back can be issued to only from the next cycle on. A source whose producer is granted write-back in the issue cycle is taken as ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Decoded instruction present |
| in_ready | output | 1 | Instruction can issue this cycle |
| in_cls | input | 2 | Operation class code (R2) |
| in_dst | input | REG_W | Destination register |
| in_src1 | input | REG_W | First source register |
| in_src2 | input | REG_W | Second source register |
| iss_grant | output | NFU | One-hot: unit receiving the issued instruction |
| rd_grant | output | NFU | Units granted an operand read this cycle |
| wb_grant | output | NFU | Unit granted write-back this cycle |
| wb_reg | output | REG_W | Destination register of the granted write-back |

## Verification
The bound checker checks, on every cycle, the properties that hold whatever the program is:
- write-back is one-hot;
- an issue grant only comes with a handshake and never comes while stalled;
- a read grant never lasts two cycles;
- a unit never receives an issue or a read grant in the same cycle as its own write-back.

Only the bench's directed programs can show the things that depend on timing and on the hazard patterns: latency counts, the structural, WAW, RAW and WAR stalls, the priority order when two units collide at write-back, and the same-cycle bypass of a finishing producer at issue.

// File: rtl/sb_pkg.sv
package sb_pkg;

    typedef enum logic [1:0] {
        FU_IDLE     = 2'd0,
        FU_WAIT_OPS = 2'd1,
        FU_EXEC     = 2'd2,
        FU_WAIT_WB  = 2'd3
    } fu_state_e;

    typedef enum logic [1:0] {
        CLS_INT = 2'd0,
        CLS_MUL = 2'd1,
        CLS_ADD = 2'd2,
        CLS_DIV = 2'd3
    } op_class_e;

endpackage

// File: rtl/sb_lowpick.sv
module sb_lowpick #(
    parameter int N = 5,
    parameter int W = 3
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt,
    output logic [W-1:0] idx,
    output logic         any
);
    // Fixed priority: the lowest index wins.
    always_comb begin
        gnt = '0;
        idx = '0;
        any = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !any) begin
                gnt[i] = 1'b1;
                idx    = W'(i);
                any    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sb_war_check.sv
module sb_war_check
    import sb_pkg::*;
#(
    parameter int NFU   = 5,
    parameter int REG_W = 5
) (
    input  fu_state_e        st [NFU],
    input  logic [REG_W-1:0] fi [NFU],
    input  logic [REG_W-1:0] fj [NFU],
    input  logic [REG_W-1:0] fk [NFU],
    input  logic             rj [NFU],
    input  logic             rk [NFU],
    output logic [NFU-1:0]   war
);
    // Unit u is blocked while another waiting unit still has to read the old value of fi[u].
    for (genvar u = 0; u < NFU; u++) begin : g_war
        always_comb begin
            war[u] = 1'b0;
            for (int v = 0; v < NFU; v++) begin
                if (v != u && st[v] == FU_WAIT_OPS &&
                    ((fj[v] == fi[u] && rj[v]) || (fk[v] == fi[u] && rk[v])))
                    war[u] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sb_fu_slot.sv
module sb_fu_slot
    import sb_pkg::*;
#(
    parameter int REG_W = 5,
    parameter int IDX_W = 3,
    parameter int LAT   = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iss_en,
    input  logic [REG_W-1:0] iss_dst,
    input  logic [REG_W-1:0] iss_src1,
    input  logic [REG_W-1:0] iss_src2,
    input  logic [IDX_W-1:0] iss_qj,
    input  logic             iss_qjv,
    input  logic [IDX_W-1:0] iss_qk,
    input  logic             iss_qkv,
    input  logic             bus_vld,
    input  logic [IDX_W-1:0] bus_idx,
    input  logic             wb_go,
    output fu_state_e        st,
    output logic [REG_W-1:0] fi,
    output logic [REG_W-1:0] fj,
    output logic [REG_W-1:0] fk,
    output logic             rj,
    output logic             rk,
    output logic             rd_req,
    output logic             done
);
    localparam int CNT_W = $clog2(LAT + 1);

    fu_state_e        st_q, st_d;
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] qj_q, qk_q;
    logic             qjv_q, qkv_q;
    logic [REG_W-1:0] fi_q, fj_q, fk_q;
    logic             rj_q, rk_q;

    // Next-state logic.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FU_IDLE:     if (iss_en)         st_d = FU_WAIT_OPS;
            FU_WAIT_OPS: if (rj_q && rk_q)   st_d = FU_EXEC;
            FU_EXEC:     if (cnt_q == CNT_W'(1)) st_d = FU_WAIT_WB;
            FU_WAIT_WB:  if (wb_go)          st_d = FU_IDLE;
            default:                         st_d = FU_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FU_IDLE;
        else        st_q <= st_d;
    end

    // Record and countdown.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            fi_q  <= '0;
            fj_q  <= '0;
            fk_q  <= '0;
            qj_q  <= '0;
            qk_q  <= '0;
            qjv_q <= 1'b0;
            qkv_q <= 1'b0;
            rj_q  <= 1'b0;
            rk_q  <= 1'b0;
        end else begin
            unique case (st_q)
                FU_IDLE: begin
                    if (iss_en) begin
                        fi_q  <= iss_dst;
                        fj_q  <= iss_src1;
                        fk_q  <= iss_src2;
                        qj_q  <= iss_qj;
                        qk_q  <= iss_qk;
                        qjv_q <= iss_qjv;
                        qkv_q <= iss_qkv;
                        rj_q  <= !iss_qjv;
                        rk_q  <= !iss_qkv;
                    end
                end
                FU_WAIT_OPS: begin
                    if (rj_q && rk_q) begin
                        rj_q  <= 1'b0;
                        rk_q  <= 1'b0;
                        cnt_q <= CNT_W'(LAT);
                    end else begin
                        if (bus_vld && qjv_q && qj_q == bus_idx) begin
                            qjv_q <= 1'b0;
                            rj_q  <= 1'b1;
                        end
                        if (bus_vld && qkv_q && qk_q == bus_idx) begin
                            qkv_q <= 1'b0;
                            rk_q  <= 1'b1;
                        end
                    end
                end
                FU_EXEC:    cnt_q <= cnt_q - CNT_W'(1);
                FU_WAIT_WB: ;
                default:    ;
            endcase
        end
    end

    // Outputs.
    always_comb begin
        st     = st_q;
        fi     = fi_q;
        fj     = fj_q;
        fk     = fk_q;
        rj     = rj_q;
        rk     = rk_q;
        rd_req = (st_q == FU_WAIT_OPS) && rj_q && rk_q;
        done   = (st_q == FU_WAIT_WB);
    end
endmodule

// File: rtl/sb_sched_ctrl.sv
module sb_sched_ctrl
    import sb_pkg::*;
#(
    parameter int REG_W   = 5,
    parameter int N_INT   = 1,
    parameter int N_MUL   = 2,
    parameter int N_ADD   = 1,
    parameter int N_DIV   = 1,
    parameter int LAT_INT = 1,
    parameter int LAT_MUL = 10,
    parameter int LAT_ADD = 2,
    parameter int LAT_DIV = 40,
    localparam int NFU    = N_INT + N_MUL + N_ADD + N_DIV
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [1:0]       in_cls,
    input  logic [REG_W-1:0] in_dst,
    input  logic [REG_W-1:0] in_src1,
    input  logic [REG_W-1:0] in_src2,
    output logic [NFU-1:0]   iss_grant,
    output logic [NFU-1:0]   rd_grant,
    output logic [NFU-1:0]   wb_grant,
    output logic [REG_W-1:0] wb_reg
);
    localparam int IDX_W  = (NFU > 1) ? $clog2(NFU) : 1;
    localparam int NREG   = 1 << REG_W;
    localparam int B_MUL  = N_INT;
    localparam int B_ADD  = N_INT + N_MUL;
    localparam int B_DIV  = N_INT + N_MUL + N_ADD;

    fu_state_e        st [NFU];
    logic [REG_W-1:0] fi [NFU];
    logic [REG_W-1:0] fj [NFU];
    logic [REG_W-1:0] fk [NFU];
    logic             rj [NFU];
    logic             rk [NFU];
    logic [NFU-1:0]   done, war, free_match, wb_cand, pick;
    logic [IDX_W-1:0] pick_idx, wb_idx;
    logic             pick_any, wb_any, fire;

    // Register result table: pending writer of each register.
    logic             rs_v [NREG];
    logic [IDX_W-1:0] rs_q [NREG];

    logic [IDX_W-1:0] qj, qk;
    logic             qjv, qkv;

    // Issue: lowest free unit of the class, no pending writer of the destination.
    sb_lowpick #(.N(NFU), .W(IDX_W)) u_iss_pick (
        .req(free_match), .gnt(pick), .idx(pick_idx), .any(pick_any)
    );

    assign in_ready  = pick_any && !rs_v[in_dst];
    assign fire      = in_valid && in_ready;
    assign iss_grant = fire ? pick : '0;

    // Producer lookup, with bypass of a producer writing back this cycle.
    always_comb begin
        qj  = rs_q[in_src1];
        qk  = rs_q[in_src2];
        qjv = rs_v[in_src1] && !(wb_any && wb_idx == rs_q[in_src1]);
        qkv = rs_v[in_src2] && !(wb_any && wb_idx == rs_q[in_src2]);
    end

    for (genvar u = 0; u < NFU; u++) begin : g_fu
        localparam logic [1:0] UCLS = (u < B_MUL) ? 2'(CLS_INT) :
                                      (u < B_ADD) ? 2'(CLS_MUL) :
                                      (u < B_DIV) ? 2'(CLS_ADD) : 2'(CLS_DIV);
        localparam int ULAT = (u < B_MUL) ? LAT_INT :
                              (u < B_ADD) ? LAT_MUL :
                              (u < B_DIV) ? LAT_ADD : LAT_DIV;

        assign free_match[u] = (st[u] == FU_IDLE) && (in_cls == UCLS);
        assign wb_cand[u]    = done[u] && !war[u];

        sb_fu_slot #(.REG_W(REG_W), .IDX_W(IDX_W), .LAT(ULAT)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .iss_en   (iss_grant[u]),
            .iss_dst  (in_dst),
            .iss_src1 (in_src1),
            .iss_src2 (in_src2),
            .iss_qj   (qj),
            .iss_qjv  (qjv),
            .iss_qk   (qk),
            .iss_qkv  (qkv),
            .bus_vld  (wb_any),
            .bus_idx  (wb_idx),
            .wb_go    (wb_grant[u]),
            .st       (st[u]),
            .fi       (fi[u]),
            .fj       (fj[u]),
            .fk       (fk[u]),
            .rj       (rj[u]),
            .rk       (rk[u]),
            .rd_req   (rd_grant[u]),
            .done     (done[u])
        );
    end

    sb_war_check #(.NFU(NFU), .REG_W(REG_W)) u_war (
        .st(st), .fi(fi), .fj(fj), .fk(fk), .rj(rj), .rk(rk), .war(war)
    );

    // Single write-back port, fixed priority by unit index.
    sb_lowpick #(.N(NFU), .W(IDX_W)) u_wb_pick (
        .req(wb_cand), .gnt(wb_grant), .idx(wb_idx), .any(wb_any)
    );

    always_comb begin
        wb_reg = '0;
        for (int u = 0; u < NFU; u++)
            if (wb_grant[u]) wb_reg = wb_reg | fi[u];
    end

    // Register result table update: clear on write-back, set on issue.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < NREG; r++) begin
                rs_v[r] <= 1'b0;
                rs_q[r] <= '0;
            end
        end else begin
            if (wb_any) rs_v[wb_reg] <= 1'b0;
            if (fire) begin
                rs_v[in_dst] <= 1'b1;
                rs_q[in_dst] <= pick_idx;
            end
        end
    end
endmodule

// File: rtl/sb_sched_chk.sv
module sb_sched_chk #(
    parameter int NFU = 5
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic           in_ready,
    input logic [NFU-1:0] iss_grant,
    input logic [NFU-1:0] rd_grant,
    input logic [NFU-1:0] wb_grant
);
    AST_WB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wb_grant)); // R9

    AST_ISSUE_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_grant != '0) |-> (in_valid && in_ready && $onehot(iss_grant))); // R5

    AST_NO_ISSUE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> (iss_grant == '0)); // R5

    AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_grant != '0) |=> ((rd_grant & $past(rd_grant)) == '0)); // R7

    AST_NO_ISSUE_ON_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_grant & wb_grant) == '0); // R10

    AST_NO_RD_ON_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_grant & wb_grant) == '0); // R8
endmodule

bind sb_sched_ctrl sb_sched_chk #(.NFU(NFU)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .iss_grant (iss_grant),
    .rd_grant  (rd_grant),
    .wb_grant  (wb_grant)
);

// File: tb/sim_sb_sched_ctrl.sv
module sim_sb_sched_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NFU = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [1:0] in_cls = 2'd0;
    logic [4:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
    logic [NFU-1:0] iss_grant, rd_grant, wb_grant;
    logic [4:0] wb_reg;

    int cyc = 0;
    int n_vec = 0;
    int n_bad = 0;
    int rd_cyc [NFU];
    int wb_cyc [NFU];
    int rd_cnt [NFU];
    int wb_at  [NFU];
    bit finished = 1'b0;

    sb_sched_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_cls(in_cls), .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
        .iss_grant(iss_grant), .rd_grant(rd_grant), .wb_grant(wb_grant),
        .wb_reg(wb_reg)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Event log, sampled away from the active edge.
    always @(negedge clk) begin
        for (int i = 0; i < NFU; i++) begin
            if (rd_grant[i]) begin
                rd_cyc[i] = cyc;
                rd_cnt[i] = rd_cnt[i] + 1;
            end
            if (wb_grant[i]) begin
                wb_cyc[i] = cyc;
                wb_at[i]  = int'(wb_reg);
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n    = 1'b0;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < NFU; i++) begin
            rd_cyc[i] = -1;
            wb_cyc[i] = -1;
            rd_cnt[i] = 0;
            wb_at[i]  = -1;
        end
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Present one instruction; return the edge label of the handshake and the unit.
    task automatic issue(input logic [1:0] c, input logic [4:0] d, input logic [4:0] s1,
                         input logic [4:0] s2, output int n, output int unit);
        in_valid = 1'b1;
        in_cls   = c;
        in_dst   = d;
        in_src1  = s1;
        in_src2  = s2;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        n    = cyc + 1;
        unit = -1;
        for (int i = 0; i < NFU; i++) if (iss_grant[i]) unit = i;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        in_cls = 2'd3;
        in_dst = 5'd17;
        #1;
        chk(in_ready == 1'b1, "R1 ready after reset", int'(in_ready), 1);
        chk(rd_grant == '0 && wb_grant == '0, "R1 no grants after reset",
            int'(rd_grant | wb_grant), 0);
    endtask

    task automatic t_latency();
        int n0, u0i, n1, u1i;
        do_reset();
        issue(2'd0, 5'd1, 5'd2, 5'd3, n0, u0i);
        issue(2'd3, 5'd10, 5'd4, 5'd6, n1, u1i);
        repeat (45) @(negedge clk);
        chk(u0i == 0, "R2 int unit", u0i, 0);
        chk(rd_cyc[0] == n0, "R2 int read cycle", rd_cyc[0], n0);
        chk(wb_cyc[0] == n0 + 2, "R2 int wb cycle", wb_cyc[0], n0 + 2);
        chk(wb_at[0] == 1, "R9 int wb_reg", wb_at[0], 1);
        chk(u1i == 4, "R2 div unit", u1i, 4);
        chk(wb_cyc[4] == n1 + 41, "R2 div wb cycle", wb_cyc[4], n1 + 41);
    endtask

    task automatic t_structural();
        int na, ua, nb, ub, nc, uc;
        do_reset();
        issue(2'd1, 5'd1, 5'd20, 5'd21, na, ua);
        issue(2'd1, 5'd2, 5'd20, 5'd21, nb, ub);
        in_cls = 2'd1;
        in_dst = 5'd3;
        #1;
        chk(in_ready == 1'b0, "R3 stall with both multipliers busy", int'(in_ready), 0);
        issue(2'd1, 5'd3, 5'd20, 5'd21, nc, uc);
        chk(ub == 2, "R2 second multiplier", ub, 2);
        chk(nc == na + 13, "R10 freed unit reissued next cycle", nc, na + 13);
        chk(uc == 1, "R3 reissue lowest free multiplier", uc, 1);
        repeat (15) @(negedge clk);
    endtask

    task automatic t_waw();
        int na, ua, nb, ub;
        do_reset();
        issue(2'd1, 5'd7, 5'd20, 5'd21, na, ua);
        issue(2'd0, 5'd7, 5'd22, 5'd23, nb, ub);
        repeat (5) @(negedge clk);
        chk(nb == na + 13, "R4 WAW issue cycle", nb, na + 13);
        chk(wb_cyc[0] == nb + 2, "R4 WAW follower wb", wb_cyc[0], nb + 2);
    endtask

    task automatic t_raw();
        int na, ua, nb, ub;
        do_reset();
        issue(2'd0, 5'd6, 5'd20, 5'd21, na, ua);
        issue(2'd2, 5'd8, 5'd6, 5'd2, nb, ub);
        repeat (8) @(negedge clk);
        chk(rd_cyc[3] == wb_cyc[0] + 1, "R6 RAW read after producer wb", rd_cyc[3], wb_cyc[0] + 1);
        chk(wb_cyc[3] == na + 6, "R6 RAW consumer wb", wb_cyc[3], na + 6);
        chk(rd_cnt[3] == 1, "R7 single read pulse", rd_cnt[3], 1);
    endtask

    task automatic t_war();
        int na, ua, nb, ub, nc, uc;
        do_reset();
        issue(2'd1, 5'd2, 5'd20, 5'd21, na, ua);
        issue(2'd2, 5'd9, 5'd2, 5'd8, nb, ub);
        issue(2'd0, 5'd8, 5'd3, 5'd4, nc, uc);
        repeat (20) @(negedge clk);
        chk(rd_cyc[3] == na + 12, "R6 reader waits for multiplier", rd_cyc[3], na + 12);
        chk(wb_cyc[0] == na + 13, "R8 WAR held until read", wb_cyc[0], na + 13);
        chk(wb_at[0] == 8, "R8 held unit wb_reg", wb_at[0], 8);
        chk(wb_cyc[3] == na + 15, "R8 reader wb", wb_cyc[3], na + 15);
    endtask

    task automatic t_priority();
        int na, ua, nb, ub;
        do_reset();
        issue(2'd2, 5'd4, 5'd20, 5'd21, na, ua);
        issue(2'd0, 5'd5, 5'd22, 5'd23, nb, ub);
        repeat (6) @(negedge clk);
        chk(wb_cyc[0] == na + 3, "R9 low index wins", wb_cyc[0], na + 3);
        chk(wb_cyc[3] == na + 4, "R9 loser one cycle later", wb_cyc[3], na + 4);
    endtask

    task automatic t_bypass();
        int na, ua, nb, ub, nc, uc, nd, ud;
        do_reset();
        issue(2'd0, 5'd5, 5'd20, 5'd21, na, ua);
        issue(2'd1, 5'd11, 5'd20, 5'd21, nb, ub);
        issue(2'd1, 5'd12, 5'd20, 5'd21, nc, uc);
        issue(2'd2, 5'd13, 5'd5, 5'd6, nd, ud);
        repeat (8) @(negedge clk);
        chk(wb_cyc[0] == na + 2 && nd == na + 3, "R10 issue on producer wb edge",
            nd, na + 3);
        chk(rd_cyc[3] == nd, "R10 bypassed source ready", rd_cyc[3], nd);
        chk(wb_cyc[3] == nd + 3, "R10 consumer wb", wb_cyc[3], nd + 3);
        repeat (12) @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_latency();
        t_structural();
        t_waw();
        t_raw();
        t_war();
        t_priority();
        t_bypass();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule